// File: doc/BRIEF.md
# Bunch-Crossing Hit Capture Memory

This block sits behind a bank of binary discriminators and keeps a record of every bunch crossing in which at least one channel fired. While a bunch train is in progress, the block ORs each channel's discriminator line over the cycles of the current crossing. A crossing strobe closes the crossing. If any channel fired, the full hit pattern of all channels is written into the next free slot of an internal record memory, tagged with the value of a free-running crossing counter. The counter advances on every crossing strobe, whether or not the crossing had hits.

Between trains, a readout request drains the filled records over a one-bit valid/ready stream. Records leave in the order they were written. Each record is sent with its identifier first, most significant bit leading, followed by channel 0 through the highest channel. The stream observes back-pressure: the data bit and the valid line hold steady for as long as ready is low, and one bit moves on each cycle in which valid and ready are both high. A full memory of 16 records of 144 bits needs 2304 accepted transfers, which is about 23 µs at 100 MHz with ready held high.

Top module: `bx_hit_recorder`

## Requirements
- R1: A rising edge of `train_i` clears the crossing counter, the record count and the overflow flag. The cycle in which the edge is seen captures nothing, so the first crossing of a train carries identifier 0.
- R2: The crossing counter starts at 0 and increases by one on every `bx_strobe_i` cycle of a train, wrapping at 16 bits. A stored record carries the counter value of the crossing it belongs to.
- R3: A crossing spans the cycles after the previous strobe, up to and including its own strobe cycle. A record is written only when at least one hit bit was seen in that span. Hits and strobes while `train_i` is low are ignored and leave the stored records unchanged.
- R4: A channel bit in a record is the OR of that channel's line over the crossing, so repeated hits on one channel collapse into a single set bit.
- R5: The memory holds 16 records, and `mem_full_o` is high exactly when 16 are stored. Once the memory is full, further hit crossings are dropped and `overflow_o` is set. `overflow_o` stays high until the next train start.
- R6: A record is serialized as 144 bits. Serial position p (0 first) carries identifier bit 15-p for p < 16 and channel p-16 for p >= 16. Filled records are sent in write order, and only filled records are sent.
- R7: After an accepted readout request with ready held high, `ser_valid_o` rises on the next cycle and stays high with no gap until the last bit is accepted, then falls.
- R8: While `ser_valid_o` is high and `ser_ready_i` is low, `ser_valid_o` stays high and `ser_data_o` holds its value.
- R9: `rd_start_i` is ignored while `train_i` is high or while a transfer is already running. `ser_valid_o` is never high in a cycle that follows a cycle with `train_i` high.
- R10: Raising `train_i` during a transfer aborts it, and `ser_valid_o` is low from the next cycle on.
- R11: After reset, `ser_valid_o`, `mem_full_o` and `overflow_o` are low. A readout request with an empty memory produces no valid data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_i | input | 1 | High while a bunch train is in progress; its rising edge starts a new train |
| bx_strobe_i | input | 1 | One-cycle pulse that closes the current crossing |
| hit_i | input | 128 | Discriminator line per channel |
| rd_start_i | input | 1 | One-cycle readout request |
| ser_ready_i | input | 1 | Stream ready from the consumer |
| ser_data_o | output | 1 | Serial record bit, meaningful while valid |
| ser_valid_o | output | 1 | Stream valid |
| mem_full_o | output | 1 | All record slots are in use |
| overflow_o | output | 1 | Sticky: a hit crossing was dropped in this train |

## Verification
The assertions assume several things about the inputs. `train_i` is a level, while `bx_strobe_i` and `rd_start_i` are single-cycle pulses. Memory content is only written while a train is running, so it stays constant during a transfer; the back-pressure hold check relies on this. The bench changes every input on the falling clock edge and pulses each strobe or request for exactly one cycle. It raises `train_i` one cycle before the first crossing, so the edge-detect cycle carries no stimulus. Ready is held high, toggled in a fixed pattern, or paired with a duplicate request in the middle of a transfer, so that both the stall path and the ignored-request path are exercised.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [0:0] {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_e;
endpackage

// File: rtl/bxr_accum.sv
module bxr_accum #(
  parameter int NCH = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture_i,
  input  logic           strobe_i,
  input  logic [NCH-1:0] hit_i,
  output logic [NCH-1:0] pattern_o,
  output logic           any_o
);
  logic [NCH-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    acc_q <= '0;
    else if (!capture_i || strobe_i) acc_q <= '0;
    else                           acc_q <= acc_q | hit_i;
  end

  assign pattern_o = acc_q | hit_i;
  assign any_o     = |pattern_o;

  // R4: bits gathered inside a crossing are never lost before its strobe
  p_acc_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && !strobe_i |=> ((acc_q & $past(pattern_o)) == $past(pattern_o)));
endmodule

// File: rtl/bxr_store.sv
module bxr_store #(
  parameter int NCH   = 128,
  parameter int ID_W  = 16,
  parameter int DEPTH = 16,
  localparam int REC_W = ID_W + NCH,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             capture_i,
  input  logic             strobe_i,
  input  logic             any_i,
  input  logic [NCH-1:0]   pattern_i,
  input  logic [PTR_W-1:0] rd_rec_i,
  output logic [REC_W-1:0] rec_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             ovf_o
);
  logic [REC_W-1:0] mem_q [DEPTH];
  logic [ID_W-1:0]  bcid_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             close_x, wr_en;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign close_x = capture_i & strobe_i;
  assign wr_en   = close_x & any_i & ~full_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcid_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (clear_i) begin
      bcid_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (close_x)                      bcid_q <= bcid_q + 1'b1;
      if (wr_en)                        cnt_q  <= cnt_q + 1'b1;
      if (close_x && any_i && full_o)   ovf_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[cnt_q[PTR_W-1:0]] <= {bcid_q, pattern_i};
  end

  assign rec_o   = mem_q[rd_rec_i];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  // R1: a train start leaves everything cleared
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0) && !ovf_q && (bcid_q == '0));
  // R2: one count per closed crossing
  p_id_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    close_x && !clear_i |=> bcid_q == $past(bcid_q) + 1'b1);
  // R5: fill count never passes capacity and stays put once full
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && !clear_i |=> full_o);
  // R5: overflow is sticky until a train start
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !clear_i |=> ovf_q);
endmodule

// File: rtl/bxr_serial.sv
module bxr_serial
  import bxr_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int REC_W = 144,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BIT_W = $clog2(REC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic             ready_i,
  output logic [PTR_W-1:0] rd_rec_o,
  output logic             data_o,
  output logic             valid_o
);
  localparam logic [BIT_W-1:0] ID_B   = BIT_W'(ID_W);
  localparam logic [BIT_W-1:0] LAST_B = BIT_W'(REC_W - 1);

  ser_state_e       state_q;
  logic [BIT_W-1:0] bit_q, sel;
  logic [CNT_W-1:0] rec_q;
  logic             take, last_bit, last_rec;

  assign take     = valid_o & ready_i;
  assign last_bit = (bit_q == LAST_B);
  assign last_rec = ((rec_q + CNT_W'(1)) == count_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      bit_q   <= '0;
      rec_q   <= '0;
    end else if (abort_i) begin
      state_q <= SER_IDLE;
      bit_q   <= '0;
      rec_q   <= '0;
    end else if (state_q == SER_IDLE) begin
      if (start_i && count_i != '0) begin
        state_q <= SER_SEND;
        bit_q   <= '0;
        rec_q   <= '0;
      end
    end else if (take) begin
      if (last_bit) begin
        bit_q <= '0;
        if (last_rec) state_q <= SER_IDLE;
        else          rec_q   <= rec_q + CNT_W'(1);
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // identifier leads, MSB first, then channels in ascending order
  always_comb begin
    if (bit_q < ID_B) sel = LAST_B - bit_q;
    else              sel = bit_q - ID_B;
  end

  assign data_o   = rec_i[sel];
  assign valid_o  = (state_q == SER_SEND);
  assign rd_rec_o = rec_q[PTR_W-1:0];

  // R8: stalled bit stays on the line
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i && !abort_i |=> valid_o && $stable(data_o));
  // R6: only filled records are addressed
  p_rec_filled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> rec_q < count_i);
  // R10: an abort empties the stream on the next cycle
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !valid_o);
endmodule

// File: rtl/bx_hit_recorder.sv
module bx_hit_recorder #(
  parameter int NCH   = 128,
  parameter int ID_W  = 16,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           train_i,
  input  logic           bx_strobe_i,
  input  logic [NCH-1:0] hit_i,
  input  logic           rd_start_i,
  input  logic           ser_ready_i,
  output logic           ser_data_o,
  output logic           ser_valid_o,
  output logic           mem_full_o,
  output logic           overflow_o
);
  localparam int REC_W = ID_W + NCH;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             train_q, train_rise, capture;
  logic [NCH-1:0]   pattern;
  logic             any_hit;
  logic [REC_W-1:0] rec;
  logic [PTR_W-1:0] rd_rec;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) train_q <= 1'b0;
    else        train_q <= train_i;
  end

  assign train_rise = train_i & ~train_q;
  assign capture    = train_i & train_q;

  bxr_accum #(.NCH(NCH)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .strobe_i  (bx_strobe_i),
    .hit_i     (hit_i),
    .pattern_o (pattern),
    .any_o     (any_hit)
  );

  bxr_store #(.NCH(NCH), .ID_W(ID_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (train_rise),
    .capture_i (capture),
    .strobe_i  (bx_strobe_i),
    .any_i     (any_hit),
    .pattern_i (pattern),
    .rd_rec_i  (rd_rec),
    .rec_o     (rec),
    .count_o   (count),
    .full_o    (mem_full_o),
    .ovf_o     (overflow_o)
  );

  bxr_serial #(.ID_W(ID_W), .REC_W(REC_W), .DEPTH(DEPTH)) u_serial (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_i  (train_i),
    .start_i  (rd_start_i),
    .count_i  (count),
    .rec_i    (rec),
    .ready_i  (ser_ready_i),
    .rd_rec_o (rd_rec),
    .data_o   (ser_data_o),
    .valid_o  (ser_valid_o)
  );

  // R9: no stream activity once a train has been seen
  p_quiet_train_r9: assert property (@(posedge clk) disable iff (!rst_n)
    train_q |-> !ser_valid_o);
  // R1: a train start drops both flags
  p_start_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    train_rise |=> !mem_full_o && !overflow_o);
endmodule

// File: tb/sim_bx_hit_recorder.sv
module sim_bx_hit_recorder;
  localparam int NCH = 128;
  localparam int RW  = 144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_i = 1'b0, bx_strobe_i = 1'b0, rd_start_i = 1'b0, ser_ready_i = 1'b0;
  logic [NCH-1:0] hit_i = '0;
  logic ser_data_o, ser_valid_o, mem_full_o, overflow_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [RW-1:0] exp_rec [0:15];
  int   exp_n = 0;
  int   exp_id = 0;
  bit   in_train = 0;

  always #2.5 clk = ~clk;

  bx_hit_recorder u0 (
    .clk(clk), .rst_n(rst_n), .train_i(train_i), .bx_strobe_i(bx_strobe_i),
    .hit_i(hit_i), .rd_start_i(rd_start_i), .ser_ready_i(ser_ready_i),
    .ser_data_o(ser_data_o), .ser_valid_o(ser_valid_o),
    .mem_full_o(mem_full_o), .overflow_o(overflow_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] ch(input int n);
    return NCH'(1) << n;
  endfunction

  task automatic train_begin();
    @(negedge clk) train_i = 1'b1;
    in_train = 1; exp_id = 0; exp_n = 0;
  endtask

  task automatic train_end();
    @(negedge clk) train_i = 1'b0;
    in_train = 0;
  endtask

  // two-cycle crossing: pattern a, then pattern b on the strobe cycle
  task automatic xing(input logic [NCH-1:0] a, input logic [NCH-1:0] b);
    logic [NCH-1:0] p;
    @(negedge clk) begin hit_i = a; bx_strobe_i = 1'b0; end
    @(negedge clk) begin hit_i = b; bx_strobe_i = 1'b1; end
    @(negedge clk) begin hit_i = '0; bx_strobe_i = 1'b0; end
    if (in_train) begin
      p = a | b;
      if (p != '0 && exp_n < 16) begin
        for (int k = 0; k < RW; k++)
          exp_rec[exp_n][k] = (k < 16) ? 1'(exp_id >> (15 - k)) : p[k-16];
        exp_n++;
      end
      exp_id = (exp_id + 1) & 16'hFFFF;
    end
  endtask

  // mode 0: ready high; 1: ready low every third cycle; 2: ready high plus a second request mid-transfer
  task automatic drain_check(input int mode, input string req);
    int got = 0, cyc = 0, gaps = 0, mism = 0, moved = 0;
    int total = exp_n * RW;
    bit prev_stall = 0;
    logic prev_d = 1'b0;
    @(negedge clk) rd_start_i = 1'b1;
    @(negedge clk) rd_start_i = 1'b0;
    while (got < total && cyc < 20000) begin
      ser_ready_i = (mode != 1) || (cyc % 3 != 2);
      rd_start_i  = (mode == 2 && cyc == 50);
      if (!ser_valid_o) begin
        gaps++;
        prev_stall = 0;
      end else begin
        if (prev_stall && ser_data_o != prev_d) moved++;
        if (ser_ready_i) begin
          if (ser_data_o != exp_rec[got / RW][got % RW]) mism++;
          got++;
        end
        prev_stall = !ser_ready_i;
        prev_d = ser_data_o;
      end
      cyc++;
      @(negedge clk);
    end
    rd_start_i = 1'b0;
    ser_ready_i = 1'b1;
    chk(got == total, req, "bits delivered", got, total);
    chk(mism == 0, "R6", "serial bit mismatches", mism, 0);
    chk(gaps == 0, "R7", "valid gaps in transfer", gaps, 0);
    chk(moved == 0, "R8", "data changed during stall", moved, 0);
    chk(ser_valid_o == 1'b0, "R7", "valid after last bit", int'(ser_valid_o), 0);
  endtask

  task automatic t_reset();
    chk(ser_valid_o == 0, "R11", "valid after reset", int'(ser_valid_o), 0);
    chk(mem_full_o == 0, "R11", "full after reset", int'(mem_full_o), 0);
    chk(overflow_o == 0, "R11", "overflow after reset", int'(overflow_o), 0);
    @(negedge clk) rd_start_i = 1'b1;
    @(negedge clk) rd_start_i = 1'b0;
    chk(ser_valid_o == 0, "R11", "valid on empty read", int'(ser_valid_o), 0);
  endtask

  task automatic t_basic();
    train_begin();
    xing(ch(5), ch(5) | ch(127));   // R4 repeated channel 5
    xing('0, '0);                    // R3 empty crossing, id 1 consumed
    xing(ch(0), ch(64));             // R2 id 2
    train_end();
    chk(exp_n == 2, "R3", "model records", exp_n, 2);
    chk(mem_full_o == 0, "R5", "full with 2 records", int'(mem_full_o), 0);
    drain_check(0, "R6");
  endtask

  task automatic t_backpressure();
    drain_check(1, "R8");
  endtask

  task automatic t_ignore();
    train_begin();
    @(negedge clk) rd_start_i = 1'b1;
    @(negedge clk) rd_start_i = 1'b0;
    chk(ser_valid_o == 0, "R9", "valid after request in train", int'(ser_valid_o), 0);
    xing(ch(9) | ch(100), ch(33));
    train_end();
    xing(ch(1), ch(2));              // R3 outside train: not recorded
    drain_check(2, "R9");
  endtask

  task automatic t_overflow();
    train_begin();
    for (int i = 0; i < 15; i++) xing(ch(i * 8), ch(i));
    chk(mem_full_o == 0, "R5", "full after 15", int'(mem_full_o), 0);
    xing(ch(77), '0);
    chk(mem_full_o == 1, "R5", "full after 16", int'(mem_full_o), 1);
    chk(overflow_o == 0, "R5", "overflow at exactly 16", int'(overflow_o), 0);
    xing(ch(3), '0);
    xing('0, ch(4));
    chk(overflow_o == 1, "R5", "overflow after drop", int'(overflow_o), 1);
    train_end();
    repeat (3) @(negedge clk);
    chk(overflow_o == 1, "R5", "overflow sticky", int'(overflow_o), 1);
    drain_check(0, "R5");
  endtask

  task automatic t_abort();
    @(negedge clk) begin rd_start_i = 1'b1; ser_ready_i = 1'b1; end
    @(negedge clk) rd_start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(ser_valid_o == 1, "R7", "valid mid transfer", int'(ser_valid_o), 1);
    train_i = 1'b1;
    in_train = 1; exp_id = 0; exp_n = 0;
    @(negedge clk);
    chk(ser_valid_o == 0, "R10", "valid after abort", int'(ser_valid_o), 0);
    chk(mem_full_o == 0, "R1", "full cleared", int'(mem_full_o), 0);
    chk(overflow_o == 0, "R1", "overflow cleared", int'(overflow_o), 0);
    xing(ch(126), '0);               // R1 first crossing gets id 0
    train_end();
    drain_check(0, "R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ser_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_ignore();
    t_overflow();
    t_abort();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule